// File: doc/BRIEF.md
# Emulator Instruction Dispatch Unit

This block sits beside the microsequencer of a microcoded minicomputer emulator. It holds the 16-bit instruction register (IR) of the emulated machine and the SKIP flag. Each clock cycle is one microinstruction, and each microinstruction carries a 4-bit function-2 code. Some function codes reload the IR from the data bus. Others compute a 4-bit dispatch value. The sequencer ORs that value into the low bits of the next microinstruction address. Two codes rewrite the low two bits of the register-select field in the same cycle, so that the emulated accumulators, held in registers 0 to 3, can be addressed from the instruction's source or destination field.

Instruction fields use the machine's own numbering, in which IR[0] is the most significant bit (vector bit 15) and IR[15] is the least significant bit (vector bit 0). The dispatch value is rebuilt from zero in every microinstruction. It appears on a registered output one cycle after the function that produced it, together with a valid strobe. The block also supplies the word returned when the microcode reads the host address: all ones in the upper byte and a parameter-set host number in the lower byte.

Top module: `emu_dispatch`

## Requirements
- R1: While `rst_n` is low, `ir_out`, `skip_out`, `mod_out` and `mod_valid` are all zero. This holds immediately, without waiting for a clock edge.
- R2: Function code 4'hE (load IR) copies `bus_in` into the IR at the clock edge. In the same cycle it registers `mod_out` = {bus vector bit 15, bus vector bits 10:8}, which is bus bit 0 followed by bus bits 5–7, and raises `mod_valid`.
- R3: Load IR clears SKIP. The clear takes priority over `skip_set` asserted in the same cycle.
- R4: With any other code, `skip_set` high sets SKIP at the clock edge. If `skip_set` is low, SKIP keeps its value.
- R5: Function code 4'hD (dispatch) registers `mod_out` from the first rule that matches. If IR[0]=1 the result is 3−IR[8-9]. If IR[1-2]=0 the result is IR[3-4]. If IR[1-2]=1 the result is 4. If IR[1-2]=2 the result is 5.
- R6: If none of the R5 rules match, the dispatch maps IR[4-7] as follows: 0→1, 1→0, 6→14, 14→6. Any other value passes through unchanged.
- R7: Function code 4'hB (source accumulator) makes `rsel_out[1:0]` = IR[1-2] XOR 3 in the same cycle. The upper bits of `rsel_in` pass through.
- R8: Function code 4'hC (destination accumulator) makes `rsel_out[1:0]` = IR[3-4] XOR 3 in the same cycle. For every other code, `rsel_out` equals `rsel_in`.
- R9: Function code 4'h8 (bus odd) registers `mod_out` = {3'b000, bus vector bit 0} with `mod_valid` high.
- R10: After any code other than 4'hE, 4'hD or 4'h8, the next cycle shows `mod_valid` low and `mod_out` zero.
- R11: Every code other than 4'hE leaves the IR unchanged. Unrecognised codes change no state except SKIP through `skip_set`.
- R12: When `host_rd` is high, `host_word` = {8'hFF, HOST_ADDR} in the same cycle. When `host_rd` is low, `host_word` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one microinstruction per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| f2_code | input | 4 | Function-2 code of the current microinstruction |
| bus_in | input | 16 | Processor data bus |
| skip_set | input | 1 | Request from the shifter logic to set SKIP |
| rsel_in | input | RSEL_W | Register-select field of the microinstruction |
| host_rd | input | 1 | Microcode reads the host address word |
| rsel_out | output | RSEL_W | Register select after accumulator rewriting |
| ir_out | output | 16 | Instruction register |
| skip_out | output | 1 | SKIP flag |
| mod_out | output | 4 | Next-address modifier |
| mod_valid | output | 1 | `mod_out` was produced by a dispatch function |
| host_word | output | 16 | Host address word, zero when not read |

## Verification
The in-RTL assertions check on every cycle the things that can be stated locally. These are: the IR changes only on load IR, load IR clears SKIP, SKIP stays put without a set, the bus-odd result, the modifier idling to zero, and `rsel_out` passing through or taking the inverted accumulator field. The dispatch priority chain, including its four remapped IR[4-7] values, can only be shown by the bench. It sweeps every 16-bit instruction against its own model of the chain. The bench also drives a reset in the middle of a cycle and reads back the host word.

// File: rtl/emu_dispatch_pkg.sv
package emu_dispatch_pkg;
  localparam int WORD_W = 16;
  localparam int MOD_W  = 4;
  localparam int ACC_W  = 2;

  localparam logic [3:0] F2_BUSODD = 4'h8;
  localparam logic [3:0] F2_ACSRC  = 4'hB;
  localparam logic [3:0] F2_ACDEST = 4'hC;
  localparam logic [3:0] F2_IDISP  = 4'hD;
  localparam logic [3:0] F2_LOADIR = 4'hE;

  function automatic logic is_mod_func(input logic [3:0] code);
    return (code == F2_LOADIR) || (code == F2_IDISP) || (code == F2_BUSODD);
  endfunction
endpackage

// File: rtl/disp_chain.sv
module disp_chain
  import emu_dispatch_pkg::*;
(
  input  logic [WORD_W-1:0] ir,
  output logic [MOD_W-1:0]  disp
);
  logic unused_low;
  assign unused_low = ^ir[5:0];

  always_comb begin
    if (ir[15]) begin
      disp = {2'b00, ~ir[7:6]};
    end else begin
      unique case (ir[14:13])
        2'd0:    disp = {2'b00, ir[12:11]};
        2'd1:    disp = 4'd4;
        2'd2:    disp = 4'd5;
        default: begin
          unique case (ir[11:8])
            4'd0:    disp = 4'd1;
            4'd1:    disp = 4'd0;
            4'd6:    disp = 4'd14;
            4'd14:   disp = 4'd6;
            default: disp = ir[11:8];
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/acc_sel.sv
module acc_sel
  import emu_dispatch_pkg::*;
#(
  parameter int RSEL_W = 5
) (
  input  logic [3:0]        f2_code,
  input  logic [3:0]        acc_fields,
  input  logic [RSEL_W-1:0] rsel_in,
  output logic [RSEL_W-1:0] rsel_out
);
  localparam int HI_W = RSEL_W - ACC_W;

  always_comb begin
    rsel_out = rsel_in;
    if (f2_code == F2_ACSRC)
      rsel_out = {rsel_in[RSEL_W-1 -: HI_W], ~acc_fields[3:2]};
    else if (f2_code == F2_ACDEST)
      rsel_out = {rsel_in[RSEL_W-1 -: HI_W], ~acc_fields[1:0]};
  end
endmodule

// File: rtl/mod_build.sv
module mod_build
  import emu_dispatch_pkg::*;
(
  input  logic [3:0]        f2_code,
  input  logic [WORD_W-1:0] bus,
  input  logic [MOD_W-1:0]  disp,
  output logic [MOD_W-1:0]  mod_d,
  output logic              valid_d
);
  logic unused_bus;
  assign unused_bus = ^{bus[14:11], bus[7:1]};

  always_comb begin
    mod_d   = '0;
    valid_d = is_mod_func(f2_code);
    unique case (f2_code)
      F2_LOADIR: mod_d = mod_d | {bus[15], bus[10:8]};
      F2_IDISP:  mod_d = mod_d | disp;
      F2_BUSODD: mod_d = mod_d | {{(MOD_W-1){1'b0}}, bus[0]};
      default:   mod_d = mod_d;
    endcase
  end
endmodule

// File: rtl/emu_dispatch.sv
module emu_dispatch
  import emu_dispatch_pkg::*;
#(
  parameter int         RSEL_W    = 5,
  parameter logic [7:0] HOST_ADDR = 8'h2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        f2_code,
  input  logic [WORD_W-1:0] bus_in,
  input  logic              skip_set,
  input  logic [RSEL_W-1:0] rsel_in,
  input  logic              host_rd,
  output logic [RSEL_W-1:0] rsel_out,
  output logic [WORD_W-1:0] ir_out,
  output logic              skip_out,
  output logic [MOD_W-1:0]  mod_out,
  output logic              mod_valid,
  output logic [WORD_W-1:0] host_word
);
  logic [WORD_W-1:0] ir_q, ir_d;
  logic              ir_en;
  logic              skip_q, skip_d;
  logic [MOD_W-1:0]  mod_q, mod_d;
  logic              valid_q, valid_d;
  logic [MOD_W-1:0]  disp;

  disp_chain u_chain (.ir(ir_q), .disp(disp));

  acc_sel #(.RSEL_W(RSEL_W)) u_acc (
    .f2_code(f2_code), .acc_fields(ir_q[14:11]),
    .rsel_in(rsel_in), .rsel_out(rsel_out)
  );

  mod_build u_mod (
    .f2_code(f2_code), .bus(bus_in), .disp(disp),
    .mod_d(mod_d), .valid_d(valid_d)
  );

  // next state
  always_comb begin
    ir_en  = (f2_code == F2_LOADIR);
    ir_d   = bus_in;
    skip_d = skip_q;
    if (ir_en)         skip_d = 1'b0;
    else if (skip_set) skip_d = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q    <= '0;
      skip_q  <= 1'b0;
      mod_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (ir_en) ir_q <= ir_d;
      skip_q  <= skip_d;
      mod_q   <= mod_d;
      valid_q <= valid_d;
    end
  end

  assign ir_out    = ir_q;
  assign skip_out  = skip_q;
  assign mod_out   = mod_q;
  assign mod_valid = valid_q;
  assign host_word = host_rd ? {8'hFF, HOST_ADDR} : '0;

  // assertions
  assert_loadir_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (f2_code == F2_LOADIR) |=> (ir_out == $past(bus_in)) && mod_valid);
  assert_skip_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (f2_code == F2_LOADIR) |=> !skip_out);
  assert_skip_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (f2_code != F2_LOADIR && !skip_set) |=> $stable(skip_out));
  assert_busodd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (f2_code == F2_BUSODD) |=> mod_valid && (mod_out == {3'b000, $past(bus_in[0])}));
  assert_idle_mod_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !is_mod_func(f2_code) |=> !mod_valid && (mod_out == '0));
  assert_ir_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (f2_code != F2_LOADIR) |=> $stable(ir_out));
  assert_acsrc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (f2_code == F2_ACSRC) |-> (rsel_out[1:0] == (ir_out[14:13] ^ 2'b11))
                              && (rsel_out[RSEL_W-1:2] == rsel_in[RSEL_W-1:2]));
  assert_acdest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (f2_code == F2_ACDEST) |-> (rsel_out[1:0] == (ir_out[12:11] ^ 2'b11)));
  assert_rsel_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (f2_code != F2_ACSRC && f2_code != F2_ACDEST) |-> (rsel_out == rsel_in));
endmodule

// File: tb/emu_dispatch_test.sv
module emu_dispatch_test;
  localparam logic [3:0] C_NOP = 4'h0, C_BODD = 4'h8, C_SRC = 4'hB,
                         C_DST = 4'hC, C_DISP = 4'hD, C_LOAD = 4'hE, C_UNK = 4'h5;
  localparam logic [7:0] HOST = 8'h2A;

  // {instruction, expected dispatch}
  localparam logic [19:0] VEC [0:11] = '{
    {16'h8000, 4'd3},  {16'h80C0, 4'd0},  {16'h1800, 4'd3},  {16'h0800, 4'd1},
    {16'h2000, 4'd4},  {16'h4000, 4'd5},  {16'h6000, 4'd1},  {16'h6100, 4'd0},
    {16'h6600, 4'd14}, {16'h6E00, 4'd6},  {16'h6500, 4'd5},  {16'h6F00, 4'd15}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  f2_code;
  logic [15:0] bus_in;
  logic        skip_set;
  logic [4:0]  rsel_in;
  logic        host_rd;
  logic [4:0]  rsel_out;
  logic [15:0] ir_out;
  logic        skip_out;
  logic [3:0]  mod_out;
  logic        mod_valid;
  logic [15:0] host_word;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  emu_dispatch #(.RSEL_W(5), .HOST_ADDR(HOST)) uut (
    .clk(clk), .rst_n(rst_n), .f2_code(f2_code), .bus_in(bus_in),
    .skip_set(skip_set), .rsel_in(rsel_in), .host_rd(host_rd),
    .rsel_out(rsel_out), .ir_out(ir_out), .skip_out(skip_out),
    .mod_out(mod_out), .mod_valid(mod_valid), .host_word(host_word)
  );

  function automatic logic irb(input logic [15:0] v, input int k);
    return v[15-k];
  endfunction

  function automatic logic [3:0] model(input logic [15:0] v);
    logic [1:0] f12, f34, f89;
    logic [3:0] f47;
    f12 = {irb(v,1), irb(v,2)};
    f34 = {irb(v,3), irb(v,4)};
    f89 = {irb(v,8), irb(v,9)};
    f47 = {irb(v,4), irb(v,5), irb(v,6), irb(v,7)};
    if (irb(v,0)) return 4'd3 - {2'b00, f89};
    if (f12 == 2'd0) return {2'b00, f34};
    if (f12 == 2'd1) return 4'd4;
    if (f12 == 2'd2) return 4'd5;
    if (f47 == 4'd0) return 4'd1;
    if (f47 == 4'd1) return 4'd0;
    if (f47 == 4'd6) return 4'd14;
    if (f47 == 4'd14) return 4'd6;
    return f47;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic apply(input logic [3:0] c, input logic [15:0] b, input logic s);
    f2_code = c; bus_in = b; skip_set = s;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; f2_code = C_NOP; bus_in = '0; skip_set = 1'b0;
    rsel_in = '0; host_rd = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 ir", ir_out, 0);
    chk("R1 skip", skip_out, 0);
    chk("R1 mod", {mod_valid, mod_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table-driven dispatch and load checks (R2, R5, R6)
    for (int i = 0; i < 12; i++) begin
      apply(C_LOAD, VEC[i][19:4], 1'b0);
      chk("R2 ir", ir_out, VEC[i][19:4]);
      chk("R2 mod", {mod_valid, mod_out}, {1'b1, VEC[i][19], VEC[i][14:12]});
      apply(C_DISP, 16'h0, 1'b0);
      chk("R5/R6 table", {mod_valid, mod_out}, {1'b1, VEC[i][3:0]});
    end

    // load mod with bus bit 0 and 5-7 set
    apply(C_LOAD, 16'h8700, 1'b0);
    chk("R2 mod full", mod_out, 4'hF);

    // accumulator selects (R7, R8), IR[1-2]=2, IR[3-4]=3
    apply(C_LOAD, 16'h5800, 1'b0);
    f2_code = C_SRC; rsel_in = 5'b11100; #1;
    chk("R7 acsrc", rsel_out, 5'b11101);
    f2_code = C_DST; rsel_in = 5'b11111; #1;
    chk("R8 acdest", rsel_out, 5'b11100);
    f2_code = C_NOP; rsel_in = 5'b01010; #1;
    chk("R8 pass", rsel_out, 5'b01010);
    @(negedge clk);

    // bus odd (R9) and idle modifier (R10)
    apply(C_BODD, 16'h0001, 1'b0);
    chk("R9 odd one", {mod_valid, mod_out}, 5'b10001);
    apply(C_BODD, 16'hFFFE, 1'b0);
    chk("R9 odd zero", {mod_valid, mod_out}, 5'b10000);
    apply(C_NOP, 16'hFFFF, 1'b0);
    chk("R10 idle", {mod_valid, mod_out}, 0);
    apply(C_SRC, 16'hFFFF, 1'b0);
    chk("R10 acsrc idle", {mod_valid, mod_out}, 0);

    // skip (R4, R3)
    apply(C_NOP, 16'h0, 1'b1);
    chk("R4 set", skip_out, 1);
    apply(C_NOP, 16'h0, 1'b0);
    chk("R4 hold", skip_out, 1);
    apply(C_UNK, 16'h1234, 1'b0);
    chk("R11 ir unchanged", ir_out, 16'h5800);
    chk("R11 skip unchanged", skip_out, 1);
    apply(C_LOAD, 16'h0000, 1'b1);
    chk("R3 clear wins", skip_out, 0);

    // host word (R12)
    host_rd = 1'b1; #1;
    chk("R12 read", host_word, {8'hFF, HOST});
    host_rd = 1'b0; #1;
    chk("R12 idle", host_word, 0);
    @(negedge clk);

    // exhaustive dispatch sweep (R5, R6)
    for (int v = 0; v < 65536; v++) begin
      apply(C_LOAD, v[15:0], 1'b0);
      apply(C_DISP, 16'h0, 1'b0);
      chk("R5/R6 sweep", mod_out, model(v[15:0]));
    end

    // asynchronous reset mid-cycle (R1)
    apply(C_LOAD, 16'hFFFF, 1'b0);
    apply(C_NOP, 16'h0, 1'b1);
    #2 rst_n = 1'b0; #1;
    chk("R1 async ir", ir_out, 0);
    chk("R1 async skip", skip_out, 0);
    chk("R1 async mod", {mod_valid, mod_out}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule